// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller

This block merges thirty-two interrupt request lines into one active-low request to a processor. Each line has its own configuration word. The word selects how the line is qualified: low level, high level, falling edge or rising edge. It also sets a 3-bit priority. An arbiter picks the most urgent unmasked pending line and holds its number as a vector.

Software reads the vector to take the interrupt. That read acknowledges the line and drops the request output. A later end-of-service write lets the arbiter signal again. Separate write-one commands enable and disable lines, force lines pending and clear latched lines. Read-only words show the sampled inputs, the pending set, the enabled pending set, the vector number and the output state.

All register traffic uses a simple bus with one write strobe and one read strobe. Read data is valid in the same cycle as the read strobe. Side effects take place at the clock edge that ends the access.

Top module: `ivc_top`

## Requirements
- R1: After reset every line is disabled, every configuration word reads 0, the enable word (0x114) reads 0, the output status word (0x118) reads 0 and `irq_n` is high.
- R2: The configuration word of line n is at byte offset 4*n. Bits [7:6] hold the trigger type and bits [2:0] hold the priority. A read returns only those fields, and all other bits read 0.
- R3: Trigger type 0 makes a line pending while its input is low, and type 1 while its input is high. The pending state follows the input with one register stage, and `irq_n` changes one clock after that.
- R4: Trigger type 2 latches a line pending on a falling input, and type 3 on a rising input. The opposite edge has no effect. The latch stays set after the input returns, until a write of 1 to that bit of the clear command word (0x12C) clears it.
- R5: Writing to 0x120 enables every line whose data bit is 1. Writing to 0x124 disables every line whose data bit is 1. Zero bits leave their lines unchanged. The enable word at 0x114 reads 1 for each enabled line. Only enabled pending lines can drive `irq_n` low.
- R6: Writing 1 to a bit of the set command word (0x128) latches that line pending, whatever its trigger type.
- R7: Among the enabled pending lines, the one with the largest priority value wins. On equal priority the lowest line number wins.
- R8: While `irq_n` is low, a read of 0x10C returns the winning line number times 4 and acknowledges the interrupt. On the next clock `irq_n` is high and the latched pending bit of that line is cleared.
- R9: From the acknowledge until a write of any value to 0x130, `irq_n` stays high and the vector number word (0x110) does not change. On the clock after the end-of-service write, arbitration runs again.
- R10: Word 0x100 reads the sampled inputs. Word 0x104 reads the pending lines, whether enabled or not. Word 0x108 reads the enabled pending lines. Bit 0 of 0x118 reads 1 while `irq_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt request lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Arbitration is tried with sets of lines that differ only in priority, and with sets that tie on priority. The first kind separates a largest-value rule from a lowest-number rule, and the second checks the tie-break. Each trigger type is driven with both edges and both levels. This shows that level lines follow their input, that edge lines latch only on the selected edge, and that the clear command releases a latch. A higher-priority line is raised during service and then served after end-of-service. This shows that the vector is frozen while in service and that arbitration starts again once service ends.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'd0,
    TRG_HIGH = 2'd1,
    TRG_FALL = 2'd2,
    TRG_RISE = 2'd3
  } trig_e;

  // word indices (byte offset / 4) of the fixed registers
  localparam int unsigned W_RAW  = 64;  // 0x100
  localparam int unsigned W_ACT  = 65;  // 0x104
  localparam int unsigned W_STAT = 66;  // 0x108
  localparam int unsigned W_VEC  = 67;  // 0x10C
  localparam int unsigned W_NUM  = 68;  // 0x110
  localparam int unsigned W_MASK = 69;  // 0x114
  localparam int unsigned W_OUT  = 70;  // 0x118
  localparam int unsigned W_MEN  = 72;  // 0x120
  localparam int unsigned W_MDIS = 73;  // 0x124
  localparam int unsigned W_SSET = 74;  // 0x128
  localparam int unsigned W_SCLR = 75;  // 0x12C
  localparam int unsigned W_EOS  = 76;  // 0x130

  // edge qualification against the previous sample
  function automatic logic edge_hit(trig_e t, logic now, logic prev);
    case (t)
      TRG_RISE: return now & ~prev;
      TRG_FALL: return ~now & prev;
      default:  return 1'b0;
    endcase
  endfunction

  // level qualification of the sampled input
  function automatic logic level_hit(trig_e t, logic smp);
    case (t)
      TRG_HIGH: return smp;
      TRG_LOW:  return ~smp;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ivc_src_slice.sv
module ivc_src_slice
  import ivc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_i,
  input  logic [1:0] trig_i,
  input  logic       set_i,
  input  logic       clr_i,
  input  logic       ack_i,
  output logic       raw_o,
  output logic       active_o
);

  logic  src_q;
  logic  latch_q;
  logic  edge_ev;
  trig_e mode;

  assign mode    = trig_e'(trig_i);
  assign edge_ev = edge_hit(mode, src_i, src_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      src_q <= src_i;
      if (set_i || edge_ev)
        latch_q <= 1'b1;
      else if (clr_i || ack_i)
        latch_q <= 1'b0;
    end
  end

  assign raw_o    = src_q;
  assign active_o = level_hit(mode, src_q) | latch_q;

  p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> active_o);

  p_soft_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> active_o);

  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !edge_ev && mode[1] && $stable(trig_i)) |=> !active_o);

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRI_W   = 3,
  localparam int unsigned VEC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            cand_i,
  input  logic [NUM_SRC-1:0][PRI_W-1:0] pri_i,
  output logic                          any_o,
  output logic [VEC_W-1:0]              win_o
);

  // largest priority wins; scanning downward with >= lets the lower index win ties
  function automatic logic [VEC_W-1:0] pick(
    input logic [NUM_SRC-1:0]            c,
    input logic [NUM_SRC-1:0][PRI_W-1:0] p
  );
    logic [VEC_W-1:0] best;
    logic [PRI_W-1:0] best_p;
    best   = '0;
    best_p = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (c[n] && (p[n] >= best_p)) begin
        best   = VEC_W'(n);
        best_p = p[n];
      end
    end
    return best;
  endfunction

  assign any_o = |cand_i;
  assign win_o = pick(cand_i, pri_i);

endmodule

// File: rtl/ivc_service.sv
module ivc_service #(
  parameter int unsigned VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [VEC_W-1:0] win_i,
  input  logic             ack_rd_i,
  input  logic             eos_i,
  output logic             irq_n_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ack_o
);

  logic             svc_q;
  logic             irq_n_q;
  logic [VEC_W-1:0] vec_q;

  // an acknowledge counts only while the request is being signalled
  assign ack_o = ack_rd_i && !svc_q && !irq_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q   <= 1'b0;
      irq_n_q <= 1'b1;
      vec_q   <= '0;
    end else if (svc_q) begin
      irq_n_q <= 1'b1;
      if (eos_i) svc_q <= 1'b0;
    end else if (ack_o) begin
      svc_q   <= 1'b1;
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= ~any_i;
      if (any_i) vec_q <= win_i;
    end
  end

  assign irq_n_o = irq_n_q;
  assign vec_o   = vec_q;

  p_ack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (irq_n_o && svc_q));

  p_hold_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q |=> $stable(vec_o));

  p_eos_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && eos_i) |=> !svc_q);

  p_quiet_in_svc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && !eos_i) |=> irq_n_o);

endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRI_W   = 3,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned VEC_W  = $clog2(NUM_SRC),
  localparam int unsigned WORD_W = ADDR_W - 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  input  logic [NUM_SRC-1:0]            raw_i,
  input  logic [NUM_SRC-1:0]            active_i,
  input  logic                          irq_n_i,
  input  logic [VEC_W-1:0]              vec_i,
  output logic [NUM_SRC-1:0][1:0]       trig_o,
  output logic [NUM_SRC-1:0][PRI_W-1:0] pri_o,
  output logic [NUM_SRC-1:0]            en_o,
  output logic [NUM_SRC-1:0]            set_o,
  output logic [NUM_SRC-1:0]            clr_o,
  output logic                          eos_o,
  output logic                          ack_rd_o
);

  logic [WORD_W-1:0]  word;
  logic               cfg_sel;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] wbits;
  logic               unused_bits;

  assign word    = addr[ADDR_W-1:2];
  assign cfg_sel = (word < WORD_W'(NUM_SRC));
  assign wbits   = wdata[NUM_SRC-1:0];
  assign unused_bits = ^{addr[1:0], wdata};

  function automatic logic hit(input logic [WORD_W-1:0] w, input int unsigned idx);
    return w == WORD_W'(idx);
  endfunction

  // per-line configuration words
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_o[n] <= 2'd0;
        pri_o[n]  <= '0;
      end else if (wr_en && hit(word, n)) begin
        trig_o[n] <= wdata[7:6];
        pri_o[n]  <= wdata[PRI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      if (hit(word, W_MEN))  en_q <= en_q | wbits;
      if (hit(word, W_MDIS)) en_q <= en_q & ~wbits;
    end
  end

  assign en_o     = en_q;
  assign set_o    = (wr_en && hit(word, W_SSET)) ? wbits : '0;
  assign clr_o    = (wr_en && hit(word, W_SCLR)) ? wbits : '0;
  assign eos_o    = wr_en && hit(word, W_EOS);
  assign ack_rd_o = rd_en && hit(word, W_VEC);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (cfg_sel) begin
        rdata[7:6]       = trig_o[word[VEC_W-1:0]];
        rdata[PRI_W-1:0] = pri_o[word[VEC_W-1:0]];
      end else if (hit(word, W_RAW))  rdata[NUM_SRC-1:0] = raw_i;
      else if (hit(word, W_ACT))      rdata[NUM_SRC-1:0] = active_i;
      else if (hit(word, W_STAT))     rdata[NUM_SRC-1:0] = active_i & en_q;
      else if (hit(word, W_VEC))      rdata[VEC_W+1:0]   = {vec_i, 2'b00};
      else if (hit(word, W_NUM))      rdata[VEC_W-1:0]   = vec_i;
      else if (hit(word, W_MASK))     rdata[NUM_SRC-1:0] = en_q;
      else if (hit(word, W_OUT))      rdata[0]           = ~irq_n_i;
    end
  end

  p_mask_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit(word, W_MEN)) |=> ((en_q & $past(wbits)) == $past(wbits)));

  p_mask_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit(word, W_MDIS)) |=> ((en_q & $past(wbits)) == '0));

  p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (hit(word, W_MEN) || hit(word, W_MDIS))) |=> $stable(en_q));

endmodule

// File: rtl/ivc_top.sv
module ivc_top #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRI_W   = 3,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned VEC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_n
);

  logic [NUM_SRC-1:0][1:0]       trig;
  logic [NUM_SRC-1:0][PRI_W-1:0] pri;
  logic [NUM_SRC-1:0]            en;
  logic [NUM_SRC-1:0]            set_cmd;
  logic [NUM_SRC-1:0]            clr_cmd;
  logic [NUM_SRC-1:0]            raw;
  logic [NUM_SRC-1:0]            active;
  logic [NUM_SRC-1:0]            cand;
  logic [NUM_SRC-1:0]            ack_oh;
  logic                          eos;
  logic                          ack_rd;
  logic                          ack;
  logic                          any_cand;
  logic [VEC_W-1:0]              win;
  logic [VEC_W-1:0]              vec;

  ivc_regfile #(
    .NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .raw_i(raw), .active_i(active), .irq_n_i(irq_n), .vec_i(vec),
    .trig_o(trig), .pri_o(pri), .en_o(en),
    .set_o(set_cmd), .clr_o(clr_cmd), .eos_o(eos), .ack_rd_o(ack_rd)
  );

  assign ack_oh = ack ? (NUM_SRC'(1) << vec) : '0;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    ivc_src_slice slice_i (
      .clk(clk), .rst_n(rst_n),
      .src_i(src_i[n]), .trig_i(trig[n]),
      .set_i(set_cmd[n]), .clr_i(clr_cmd[n]), .ack_i(ack_oh[n]),
      .raw_o(raw[n]), .active_o(active[n])
    );
  end

  assign cand = active & en;

  ivc_arbiter #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W)) arb_i (
    .cand_i(cand), .pri_i(pri), .any_o(any_cand), .win_o(win)
  );

  ivc_service #(.VEC_W(VEC_W)) svc_i (
    .clk(clk), .rst_n(rst_n),
    .any_i(any_cand), .win_i(win),
    .ack_rd_i(ack_rd), .eos_i(eos),
    .irq_n_o(irq_n), .vec_o(vec), .ack_o(ack)
  );

  p_win_is_cand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_cand |-> cand[win]);

  p_irq_from_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(any_cand));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_cmd[vec] && trig[vec][1] && $stable(src_i)) |=> !active[$past(vec)]);

endmodule

// File: tb/ivc_top_tb.sv
module ivc_top_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NTAB = 6;

  localparam logic [31:0] SET_TBL [NTAB] = '{
    32'h0000_0006,   // lines 1,2   prio 5,2
    32'h0000_0808,   // lines 3,11  prio 7,7  tie
    32'h0000_0101,   // lines 0,8   prio 0,0  tie
    32'h8000_0000,   // line 31 alone
    32'h0000_0250,   // lines 4,6,9 prio 4,6,5
    32'h4000_4000    // lines 14,30 prio 6,6  tie
  };
  localparam int WIN_TBL [NTAB] = '{1, 3, 0, 31, 6, 14};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ivc_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int prio_of(int n);
    return (n * 5) % 8;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 irq_n", 32'(irq_n), 32'd1);
    rd(10'h114, d); chk("R1 enable word", d, 32'h0);
    rd(10'h014, d); chk("R1 cfg5", d, 32'h0);
    rd(10'h118, d); chk("R1 out status", d, 32'h0);

    // R2 configuration field layout
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, d); chk("R2 cfg5 fields", d, 32'h0000_00C7);
    wr(10'h07C, 32'h0000_0045);
    rd(10'h07C, d); chk("R2 cfg31 fields", d, 32'h0000_0045);
    rd(10'h014, d); chk("R2 cfg5 unchanged", d, 32'h0000_00C7);

    // R5 enable / disable write-one
    wr(10'h120, 32'h0000_00F0);
    wr(10'h120, 32'h0000_0003);
    rd(10'h114, d); chk("R5 enable or", d, 32'h0000_00F3);
    wr(10'h124, 32'h0000_0030);
    rd(10'h114, d); chk("R5 disable", d, 32'h0000_00C3);
    wr(10'h124, 32'hFFFF_FFFF);
    rd(10'h114, d); chk("R5 all off", d, 32'h0);

    // R3 level modes
    wr(10'h008, 32'h0000_0044);   // line 2 high level prio 4
    wr(10'h00C, 32'h0000_0001);   // line 3 low level prio 1
    wr(10'h120, 32'h0000_0004);
    step(1);
    chk("R5 masked low-level lines quiet", 32'(irq_n), 32'd1);
    src[2] = 1'b1;
    step(2);
    chk("R3 high level asserts", 32'(irq_n), 32'd0);
    rd(10'h100, d); chk("R10 raw word", d, 32'h0000_0004);
    rd(10'h108, d); chk("R10 status word", d, 32'h0000_0004);
    rd(10'h118, d); chk("R10 out status", d, 32'h1);
    src[2] = 1'b0;
    step(2);
    chk("R3 high level follows input", 32'(irq_n), 32'd1);
    wr(10'h120, 32'h0000_0008);
    step(1);
    chk("R3 low level asserts", 32'(irq_n), 32'd0);
    rd(10'h110, d); chk("R10 vector number", d, 32'd3);
    rd(10'h104, d); chk("R10 pending word bit3", d & 32'h0000_000C, 32'h0000_0008);
    src[3] = 1'b1;
    step(2);
    chk("R3 low level follows input", 32'(irq_n), 32'd1);
    wr(10'h124, 32'h0000_000C);

    // R4 edge modes
    wr(10'h01C, 32'h0000_0082);   // line 7 falling edge prio 2
    wr(10'h120, 32'h0000_0080);
    src[7] = 1'b1;
    step(2);
    chk("R4 wrong edge ignored", 32'(irq_n), 32'd1);
    rd(10'h104, d); chk("R4 no pending on wrong edge", d & 32'h80, 32'h0);
    src[7] = 1'b0;
    step(2);
    chk("R4 falling edge asserts", 32'(irq_n), 32'd0);
    src[7] = 1'b1;
    step(2);
    chk("R4 latch holds", 32'(irq_n), 32'd0);
    rd(10'h108, d); chk("R4 status latched", d, 32'h0000_0080);
    wr(10'h12C, 32'h0000_0080);
    rd(10'h108, d); chk("R4 clear command", d, 32'h0);
    step(1);
    chk("R4 irq released", 32'(irq_n), 32'd1);
    wr(10'h124, 32'hFFFF_FFFF);

    // table: all lines rising edge with prio (n*5)%8, software set
    for (int n = 0; n < 32; n++)
      wr(10'(4 * n), 32'h0000_00C0 | 32'(prio_of(n)));
    wr(10'h120, 32'hFFFF_FFFF);
    step(1);
    chk("R6 no spurious edge", 32'(irq_n), 32'd1);
    for (int i = 0; i < NTAB; i++) begin
      wr(10'h128, SET_TBL[i]);
      step(1);
      chk("R6 set asserts", 32'(irq_n), 32'd0);
      rd(10'h10C, d); chk("R7 winner vector", d, 32'(WIN_TBL[i] * 4));
      chk("R8 ack deasserts", 32'(irq_n), 32'd1);
      rd(10'h108, d);
      chk("R8 ack clears winner", d, SET_TBL[i] & ~(32'd1 << WIN_TBL[i]));
      wr(10'h12C, 32'hFFFF_FFFF);
      wr(10'h130, 32'h0);
      step(1);
      chk("R4 clear then idle", 32'(irq_n), 32'd1);
    end

    // R9 service window and re-arbitration
    wr(10'h128, 32'h0000_0006);
    step(1);
    rd(10'h10C, d); chk("R8 first vector", d, 32'd4);
    wr(10'h128, 32'h0000_0008);   // line 3, prio 7, arrives in service
    step(2);
    chk("R9 quiet during service", 32'(irq_n), 32'd1);
    rd(10'h110, d); chk("R9 vector frozen", d, 32'd1);
    rd(10'h10C, d); chk("R9 read in service no new ack", d, 32'd4);
    wr(10'h130, 32'h0);
    chk("R9 still quiet at eos edge", 32'(irq_n), 32'd1);
    step(1);
    chk("R9 rearmed", 32'(irq_n), 32'd0);
    rd(10'h10C, d); chk("R7 higher prio served next", d, 32'd12);
    wr(10'h130, 32'h0);
    step(1);
    rd(10'h10C, d); chk("R9 remaining line served", d, 32'd8);
    wr(10'h130, 32'h0);
    step(1);
    chk("R9 idle after all served", 32'(irq_n), 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule